// File: doc/BRIEF.md
# BCD Clock Calendar with 12-Hour Encoding

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day-of-week, day of month, month and a two-digit year, all in packed BCD. Each pulse on the one-second enable advances the seconds, and carries ripple upward through the calendar in the same clock cycle. Month lengths and leap Februaries are handled automatically.

The hour field has two formats, chosen by a mode input. In 24-hour format it counts 00 to 23. In 12-hour format bit 5 of the hour marks the afternoon, so noon reads 32, 1 PM reads 21 and 11 PM reads 31. AM hours read 12, 01 to 11. Changing the mode does not convert the stored hour. It only changes how later increments behave.

A host loads fields through a simple write port. A hold input freezes counting while the host reads or writes a consistent set of fields. A tick that arrives during hold, or during a write cycle, is kept as one pending step. That step is applied in the first cycle in which neither hold nor a write is present.

Top module: `bcd_clock_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. A step at 59 returns the field to 00 and advances the next field up in the same cycle.
- R2: With mode_24=1 the hour counts 00 to 23. A step from 23:59:59 gives 00:00:00 and advances both the day and the day-of-week.
- R3: With mode_24=0 the hour code is BCD 12, 01..11 for AM and the same BCD with bit 5 set for PM (32, 21..31). The step from 11 AM (0x11) gives 0x32 with no day carry. The step from 11 PM (0x31) gives 0x12 and advances the day. The step from 0x12 gives 0x01, and the step from 0x32 gives 0x21.
- R4: Day-of-week is a 3-bit value that counts 0..6 and returns to 0. It advances exactly when the day advances.
- R5: The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. The step after the last day gives day 01 and advances the month.
- R6: February ends on day 29 when the BCD year is a multiple of four, 00 included, and on day 28 otherwise.
- R7: Months count 01..12. The step after December gives 01 and advances the year. The year counts 00..99 and wraps to 00.
- R8: While hold=1 no field changes unless it is written. A tick during hold or during a write cycle is stored, and at most one such tick is stored. That tick advances the clock by one second in the first cycle in which hold=0 and wr_en=0.
- R9: A write with wr_en=1 stores wr_data in the field selected by wr_addr: 0 seconds, 1 minutes, 2 hour, 3 day-of-week, 4 day, 5 month, 6 year. Address 7 changes nothing. The value is masked to the field width (7, 7, 6, 3, 6, 5 and 8 bits) and can be read on the next cycle.
- R10: A write to the seconds field discards any stored tick, including a tick in the same cycle.
- R11: After reset the fields read seconds 00, minutes 00, hour 00, day-of-week 0, day 01, month 01 and year 00.
- R12: Changing mode_24 leaves the stored hour code as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-second enable, one cycle wide |
| hold | input | 1 | Freeze counting; ticks are deferred |
| mode_24 | input | 1 | 1 selects the 24-hour format, 0 selects the 12-hour format |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Field select for a write |
| wr_data | input | 8 | Write data in BCD |
| sec_q | output | 7 | Seconds in BCD |
| min_q | output | 7 | Minutes in BCD |
| hour_q | output | 6 | Hour code in BCD; bit 5 is the PM flag in 12-hour format |
| wday_q | output | 3 | Day-of-week, 0..6 |
| day_q | output | 6 | Day of month in BCD |
| mon_q | output | 5 | Month in BCD |
| year_q | output | 8 | Two-digit year in BCD |

## Verification
The bench drives the full rollover at the end of a year, where seconds, minutes, hours, day, month and year all wrap in one step. A broken carry chain would leave one field stale or let a carry reach too far. It drives February at years 03, 04 and 00, and the ends of 30-day and 31-day months. A wrong leap rule or a wrong month-length table would skip or repeat a day.

In 12-hour format it steps 11 AM, 11 PM and 12 through their rollovers. A design that flipped the PM flag at the wrong hour would show a wrong afternoon code, or move the day at noon. Ticks arrive during hold, during writes, and together with a seconds write. A design that dropped the stored tick, applied it twice, or kept it after the seconds write would end up one second off.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int WDAY_W = 3;
  localparam int DAY_W  = 6;
  localparam int MON_W  = 5;
  localparam int YEAR_W = 8;
  localparam int NFLD   = 7;

  typedef enum logic [ADDR_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_DAY  = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6,
    F_NONE = 3'd7
  } fld_e;

  // Packed BCD increment of two digits.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // A BCD year is a multiple of four when 2*tens_lsb + ones is, modulo 4.
  function automatic logic yr_leap(input logic [7:0] yr);
    logic [1:0] s;
    s = {yr[4], 1'b0} + yr[1:0];
    return (s == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [7:0] r;
    case (mon)
      5'h02:                      r = yr_leap(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_tick_gate.sv
module cal_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic busy,
  input  logic sec_wr,
  output logic step,
  output logic pend_q
);

  logic pend_nxt;
  logic blocked;

  assign blocked = hold | busy;
  assign step    = ~blocked & (tick | pend_q);

  always_comb begin
    pend_nxt = pend_q;
    if (sec_wr)                   pend_nxt = 1'b0;
    else if (blocked && tick)     pend_nxt = 1'b1;
    else if (step && pend_q && tick) pend_nxt = 1'b1;
    else if (step)                pend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_nxt;
  end

endmodule

// File: rtl/cal_bcd_counter.sv
module cal_bcd_counter #(
  parameter int           W   = 7,
  parameter logic [W-1:0] LOW = '0,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic [7:0]   limit,
  output logic [W-1:0] value,
  output logic         wrap
);
  import bcd_cal_pkg::*;

  logic [7:0]   cur;
  logic         at_top;
  logic [7:0]   incd;
  logic [W-1:0] nxt;
  logic         en;

  assign cur    = 8'(value);
  assign at_top = (cur >= limit);
  assign wrap   = inc & at_top;
  assign incd   = bcd_inc(cur);
  assign en     = wr | inc;

  always_comb begin
    if (wr)          nxt = wr_data;
    else if (at_top) nxt = LOW;
    else             nxt = incd[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value <= RST;
    else if (en) value <= nxt;
  end

endmodule

// File: rtl/cal_hour_counter.sv
module cal_hour_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         mode_24,
  output logic [W-1:0] value,
  output logic         carry
);
  import bcd_cal_pkg::*;

  localparam logic [4:0] H11 = 5'h11;
  localparam logic [4:0] H12 = 5'h12;

  logic [W-1:0] nxt;
  logic [7:0]   inc24;
  logic [7:0]   inc12;
  logic [4:0]   h12;
  logic         pm;
  logic         en;

  assign h12   = value[4:0];
  assign pm    = value[5];
  assign inc24 = bcd_inc(8'(value));
  assign inc12 = bcd_inc(8'(h12));
  assign en    = wr | inc;

  always_comb begin
    carry = 1'b0;
    if (wr) begin
      nxt = wr_data;
    end else if (mode_24) begin
      if (8'(value) >= 8'h23) begin
        nxt   = '0;
        carry = inc;
      end else begin
        nxt = inc24[W-1:0];
      end
    end else begin
      if (h12 == H12) begin
        nxt = {pm, 5'h01};
      end else if (h12 == H11) begin
        nxt   = {~pm, H12};
        carry = inc & pm;
      end else begin
        nxt = {pm, inc12[4:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value <= '0;
    else if (en) value <= nxt;
  end

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import bcd_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic              hold,
  input  logic              mode_24,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEC_W-1:0]  sec_q,
  output logic [MIN_W-1:0]  min_q,
  output logic [HOUR_W-1:0] hour_q,
  output logic [WDAY_W-1:0] wday_q,
  output logic [DAY_W-1:0]  day_q,
  output logic [MON_W-1:0]  mon_q,
  output logic [YEAR_W-1:0] year_q
);

  logic [NFLD-1:0] sel;
  logic            step;
  logic            pend_q;
  logic [1:0]      ms_wrap;
  logic [6:0]      ms_val [2];
  logic            day_carry;
  logic            day_wrap;
  logic            mon_wrap;
  logic            wday_wrap_unused;
  logic            year_wrap_unused;
  logic [7:0]      day_limit;

  always_comb begin
    sel = '0;
    if (wr_en && (wr_addr != F_NONE)) sel = NFLD'(1) << wr_addr;
  end

  cal_tick_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_1s),
    .hold   (hold),
    .busy   (wr_en),
    .sec_wr (sel[F_SEC]),
    .step   (step),
    .pend_q (pend_q)
  );

  // Seconds and minutes share one shape: 00..59.
  for (genvar g = 0; g < 2; g++) begin : g_ms
    cal_bcd_counter #(.W(7), .LOW(7'h00), .RST(7'h00)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     ((g == 0) ? step : ms_wrap[0]),
      .wr      (sel[g]),
      .wr_data (wr_data[6:0]),
      .limit   (8'h59),
      .value   (ms_val[g]),
      .wrap    (ms_wrap[g])
    );
  end

  assign sec_q = ms_val[0];
  assign min_q = ms_val[1];

  cal_hour_counter #(.W(HOUR_W)) u_hour (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (ms_wrap[1]),
    .wr      (sel[F_HOUR]),
    .wr_data (wr_data[HOUR_W-1:0]),
    .mode_24 (mode_24),
    .value   (hour_q),
    .carry   (day_carry)
  );

  cal_bcd_counter #(.W(WDAY_W), .LOW(3'd0), .RST(3'd0)) u_wday (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (day_carry),
    .wr      (sel[F_WDAY]),
    .wr_data (wr_data[WDAY_W-1:0]),
    .limit   (8'h06),
    .value   (wday_q),
    .wrap    (wday_wrap_unused)
  );

  assign day_limit = last_day(mon_q, year_q);

  cal_bcd_counter #(.W(DAY_W), .LOW(6'h01), .RST(6'h01)) u_day (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (day_carry),
    .wr      (sel[F_DAY]),
    .wr_data (wr_data[DAY_W-1:0]),
    .limit   (day_limit),
    .value   (day_q),
    .wrap    (day_wrap)
  );

  cal_bcd_counter #(.W(MON_W), .LOW(5'h01), .RST(5'h01)) u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (day_wrap),
    .wr      (sel[F_MON]),
    .wr_data (wr_data[MON_W-1:0]),
    .limit   (8'h12),
    .value   (mon_q),
    .wrap    (mon_wrap)
  );

  cal_bcd_counter #(.W(YEAR_W), .LOW(8'h00), .RST(8'h00)) u_year (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (mon_wrap),
    .wr      (sel[F_YEAR]),
    .wr_data (wr_data[YEAR_W-1:0]),
    .limit   (8'h99),
    .value   (year_q),
    .wrap    (year_wrap_unused)
  );

endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hold,
  input logic       mode_24,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [6:0] sec_q,
  input logic [6:0] min_q,
  input logic [5:0] hour_q,
  input logic [2:0] wday_q,
  input logic [5:0] day_q,
  input logic       step,
  input logic       pend_q
);

  a_r1_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sec_q == 7'h59) |=> (sec_q == 7'h00 && min_q != $past(min_q)));

  a_r2_day_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_24 && sec_q == 7'h59 && min_q == 7'h59 && hour_q == 6'h23)
      |=> (hour_q == 6'h00 && day_q != $past(day_q)));

  a_r4_wday_no7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(wday_q) != 3'd7) |-> (wday_q != 3'd7));

  a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(day_q)));

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !hold && !wr_en) |=> (sec_q != $past(sec_q)));

  a_r10_sec_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> !pend_q);

endmodule

bind bcd_clock_calendar cal_checker u_cal_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .hold    (hold),
  .mode_24 (mode_24),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .sec_q   (sec_q),
  .min_q   (min_q),
  .hour_q  (hour_q),
  .wday_q  (wday_q),
  .day_q   (day_q),
  .step    (step),
  .pend_q  (pend_q)
);

// File: tb/bcd_clock_calendar_bench.sv
module bcd_clock_calendar_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1s, hold, mode_24, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q;
  logic [2:0] wday_q;
  logic [5:0] day_q;
  logic [4:0] mon_q;
  logic [7:0] year_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state: binary values, hour kept as its code
  int   ms, mm, mwd, md, mmo, my;
  logic [7:0] mh;
  bit   mp;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_clock_calendar u_bcd_clock_calendar (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .hold(hold), .mode_24(mode_24),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .wday_q(wday_q),
    .day_q(day_q), .mon_q(mon_q), .year_q(year_q)
  );

  function automatic int bcd2bin(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_hour_step(output bit carry);
    int h24;
    int h12;
    if (mode_24) h24 = bcd2bin(mh);
    else h24 = (bcd2bin({3'b000, mh[4:0]}) % 12) + (mh[5] ? 12 : 0);
    carry = (h24 == 23);
    h24 = (h24 + 1) % 24;
    if (mode_24) mh = bin2bcd(h24);
    else begin
      h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
      mh = bin2bcd(h12) | ((h24 >= 12) ? 8'h20 : 8'h00);
    end
  endtask

  task automatic model_advance();
    bit c;
    ms++;
    if (ms < 60) return;
    ms = 0; mm++;
    if (mm < 60) return;
    mm = 0;
    model_hour_step(c);
    if (!c) return;
    mwd = (mwd + 1) % 7;
    md++;
    if (md <= mdays(mmo, my)) return;
    md = 1; mmo++;
    if (mmo <= 12) return;
    mmo = 1; my = (my + 1) % 100;
  endtask

  task automatic model_edge(input bit t, input bit h, input bit w, input logic [2:0] a, input logic [7:0] d);
    bit st;
    bit secw;
    st   = !h && !w && (t || mp);
    secw = w && a == 3'd0;
    if (w) begin
      case (a)
        3'd0: ms  = bcd2bin(d & 8'h7F);
        3'd1: mm  = bcd2bin(d & 8'h7F);
        3'd2: mh  = d & 8'h3F;
        3'd3: mwd = int'(d[2:0]);
        3'd4: md  = bcd2bin(d & 8'h3F);
        3'd5: mmo = bcd2bin(d & 8'h1F);
        3'd6: my  = bcd2bin(d);
        default: ;
      endcase
    end
    if (secw)                   mp = 0;
    else if ((h || w) && t)     mp = 1;
    else if (st && mp && t)     mp = 1;
    else if (st)                mp = 0;
    if (st) model_advance();
  endtask

  task automatic check_all();
    chk("R1", "sec",  int'(sec_q),  int'(bin2bcd(ms)));
    chk("R1", "min",  int'(min_q),  int'(bin2bcd(mm)));
    chk(mode_24 ? "R2" : "R3", "hour", int'(hour_q), int'(mh));
    chk("R4", "wday", int'(wday_q), mwd);
    chk("R5", "day",  int'(day_q),  int'(bin2bcd(md)));
    chk("R7", "mon",  int'(mon_q),  int'(bin2bcd(mmo)));
    chk("R7", "year", int'(year_q), int'(bin2bcd(my)));
  endtask

  // called at a falling edge: drive, let the rising edge pass, check at next falling edge
  task automatic cyc(input bit t, input bit h, input bit w, input logic [2:0] a, input logic [7:0] d);
    tick_1s = t; hold = h; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge(t, h, w, a, d);
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(0, 0, 1, a, d);
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                         input logic [7:0] wd, input logic [7:0] dd, input logic [7:0] mo,
                         input logic [7:0] y);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, wd);
    wr(3'd5, mo); wr(3'd4, dd); wr(3'd6, y);
  endtask

  task automatic tick1();
    cyc(1, 0, 0, 3'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s0;
    void'($urandom(32'd20240611));
    rst_n = 0; tick_1s = 0; hold = 0; mode_24 = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    ms = 0; mm = 0; mh = 8'h00; mwd = 0; md = 1; mmo = 1; my = 0; mp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "sec",  int'(sec_q), 0);
    chk("R11", "hour", int'(hour_q), 0);
    chk("R11", "day",  int'(day_q), 1);
    chk("R11", "mon",  int'(mon_q), 1);
    chk("R11", "year", int'(year_q), 0);
    chk("R11", "wday", int'(wday_q), 0);

    // R2 R4 R7: full year rollover in 24-hour format
    set_all(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    tick1();
    chk("R2", "hour", int'(hour_q), 0);
    chk("R4", "wday", int'(wday_q), 0);
    chk("R7", "mon",  int'(mon_q), 1);
    chk("R7", "year", int'(year_q), 0);

    // R6 February ends
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h03);
    tick1();
    chk("R6", "day y03", int'(day_q), 1);
    chk("R6", "mon y03", int'(mon_q), 3);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h04);
    tick1();
    chk("R6", "day y04", int'(day_q), 8'h29);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h00);
    tick1();
    chk("R6", "mon y00", int'(mon_q), 3);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    tick1();
    chk("R6", "mon y10", int'(mon_q), 3);

    // R5 month lengths
    set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21);
    tick1();
    chk("R5", "apr30", int'(mon_q), 5);
    set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h21);
    tick1();
    chk("R5", "jan30", int'(day_q), 8'h31);

    // R12 mode change keeps the code
    wr(3'd2, 8'h15);
    mode_24 = 0;
    @(negedge clk);
    chk("R12", "hour", int'(hour_q), 8'h15);

    // R3 12-hour rollovers
    set_all(8'h59, 8'h59, 8'h11, 8'h00, 8'h10, 8'h06, 8'h21);
    tick1();
    chk("R3", "11am->", int'(hour_q), 8'h32);
    chk("R3", "noon day", int'(day_q), 8'h10);
    set_all(8'h59, 8'h59, 8'h31, 8'h00, 8'h10, 8'h06, 8'h21);
    tick1();
    chk("R3", "11pm->", int'(hour_q), 8'h12);
    chk("R3", "midnight day", int'(day_q), 8'h11);
    set_all(8'h59, 8'h59, 8'h12, 8'h00, 8'h10, 8'h06, 8'h21);
    tick1();
    chk("R3", "12am->", int'(hour_q), 8'h01);
    set_all(8'h59, 8'h59, 8'h32, 8'h00, 8'h10, 8'h06, 8'h21);
    tick1();
    chk("R3", "12pm->", int'(hour_q), 8'h21);
    mode_24 = 1;
    wr(3'd2, 8'h08);

    // R8 deferral: two ticks in hold give one step
    wr(3'd0, 8'h20);
    cyc(1, 1, 0, 3'd0, 8'h00);
    cyc(1, 1, 0, 3'd0, 8'h00);
    cyc(0, 1, 0, 3'd0, 8'h00);
    chk("R8", "frozen", int'(sec_q), 8'h20);
    cyc(0, 0, 0, 3'd0, 8'h00);
    chk("R8", "applied", int'(sec_q), 8'h21);
    cyc(0, 0, 0, 3'd0, 8'h00);
    chk("R8", "once", int'(sec_q), 8'h21);
    // tick during a write cycle is deferred
    cyc(1, 0, 1, 3'd1, 8'h30);
    cyc(0, 0, 0, 3'd0, 8'h00);
    chk("R8", "wr defer", int'(sec_q), 8'h22);

    // R10 seconds write drops the stored tick
    cyc(1, 1, 0, 3'd0, 8'h00);
    cyc(1, 0, 1, 3'd0, 8'h10);
    cyc(0, 0, 0, 3'd0, 8'h00);
    cyc(0, 0, 0, 3'd0, 8'h00);
    chk("R10", "sec", int'(sec_q), 8'h10);

    // R9 masking and ignored address
    wr(3'd0, 8'hD9);
    chk("R9", "mask", int'(sec_q), 8'h59);
    s0 = {1'b0, sec_q};
    wr(3'd7, 8'h33);
    chk("R9", "addr7", int'(sec_q), int'(s0));

    // random phase
    for (int ph = 0; ph < 2; ph++) begin
      mode_24 = (ph == 0);
      wr(3'd2, 8'h11);
      for (int i = 0; i < 8000; i++) begin
        bit t, h, w;
        logic [2:0] a;
        logic [7:0] d;
        int r;
        t = ($urandom % 2) == 0;
        h = ($urandom % 8) == 0;
        w = ($urandom % 10) == 0;
        a = 3'($urandom % 8);
        case (a)
          3'd0: d = bin2bcd(($urandom % 4 == 0) ? 59 : int'($urandom % 60));
          3'd1: d = bin2bcd(($urandom % 2 == 0) ? 59 : int'($urandom % 60));
          3'd2: begin
            r = int'($urandom % 24);
            if (mode_24) d = bin2bcd(r);
            else d = bin2bcd((r % 12 == 0) ? 12 : r % 12) | ((r >= 12) ? 8'h20 : 8'h00);
          end
          3'd3: d = 8'($urandom % 7);
          3'd4: d = bin2bcd(1 + int'($urandom % 28));
          3'd5: d = bin2bcd(1 + int'($urandom % 12));
          default: d = bin2bcd(int'($urandom % 100));
        endcase
        cyc(t, h, w, a, d);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule